// File: doc/BRIEF.md
# Iterative Quadratic-Rotation Block Cipher Core

This core encrypts or decrypts one block of four words per job. The words are A, B, C and D, each `WORD_W` bits wide. Each round mixes the block with rotations whose amounts depend on the data. The amounts come from the quadratic x*(2x+1), taken modulo 2^w and then rotated left by log2(w). Key words are added before the first round and after the last round. A direction select chooses the operation. Decryption undoes encryption: it runs the rounds in reverse order and moves the words at the start of each round.

An upstream source offers a block with `inAvail`. The core takes it in a cycle where it is idle and pulses `inRead`. The core never stores the key table. It drives `roundNum`, a pair index p, and an external key memory returns the words S[2p] and S[2p+1] on `keyWord` with `keyAvail`. The core then moves through whitening, `NUM_ROUNDS` rounds and the final whitening, doing one step per cycle in which a key pair is present. It holds the result on `dataOut` until the downstream side is not full, and then pulses `outWrite`.

Top module: `quad_rot_cipher`

## Requirements
- R1: Encryption follows these steps. It starts with B += S[0] and D += S[1]. Then, for rounds i = 1..r: t = rotl(B*(2B+1), log2 w), u = rotl(D*(2D+1), log2 w), A = rotl(A^t, u) + S[2i], C = rotl(C^u, t) + S[2i+1], and the words move so that (A,B,C,D) becomes (B,C,D,A). It ends with A += S[2r+2] and C += S[2r+3]. All arithmetic is modulo 2^w, and rotations use only the low log2(w) bits of the amount. Blocks are packed as {A,B,C,D}, with A in the most significant word.
- R2: Key pair p is presented as `keyWord` = {S[2p+1], S[2p]}. The even word sits in the low half. Pair 0 and pair r+1 hold the whitening words.
- R3: Decryption follows these steps. It starts with C -= S[2r+3] and A -= S[2r+2]. Then, for rounds i = r down to 1: the words first move so that (A,B,C,D) becomes (D,A,B,C), then t and u are computed from B and D, C = rotr(C - S[2i+1], t) ^ u and A = rotr(A - S[2i], u) ^ t. It ends with D -= S[1] and B -= S[0]. Decrypting a ciphertext returns the original plaintext.
- R4: `keyRead` is high only in a cycle where `keyAvail` is high. The block changes only in cycles where a key pair is consumed. At most one of `inRead`, `keyRead` and `outWrite` is high in any cycle.
- R5: With `keyAvail` held high and the output side not full, `outWrite` goes high exactly r+3 cycles after the cycle in which `inRead` was high. Each cycle that `keyAvail` is low during processing adds exactly one cycle.
- R6: `inRead` is high only while `ready` and `inAvail` are both high, and the block on `dataIn` is captured in that cycle. `ready` is low from the next cycle until the result has been delivered.
- R7: While a finished result waits and `outFull` is high: `outWrite` stays low, `dataOut` stays stable, and no new block is accepted even with `inAvail` high. In the first cycle with `outFull` low, `outWrite` pulses and the core returns to ready.
- R8: After reset: `ready` is 1, `inRead`, `keyRead` and `outWrite` are 0, and `dataOut` is 0.
- R9: `roundNum` steps from 0 up to r+1 for encryption and from r+1 down to 0 for decryption. It never exceeds r+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| encSel | input | 1 | 1 = encrypt, 0 = decrypt; sampled with `inRead` |
| dataIn | input | 4*WORD_W | Input block {A,B,C,D} |
| inAvail | input | 1 | Upstream block offered |
| inRead | output | 1 | Block taken this cycle |
| dataOut | output | 4*WORD_W | Working/result block {A,B,C,D} |
| outFull | input | 1 | Downstream cannot take a result |
| outWrite | output | 1 | Result transferred this cycle |
| roundNum | output | $clog2(NUM_ROUNDS+2) | Key pair index requested |
| keyWord | input | 2*WORD_W | {S[2p+1], S[2p]} for pair p = roundNum |
| keyAvail | input | 1 | Key pair on `keyWord` is valid |
| keyRead | output | 1 | Key pair consumed this cycle |
| ready | output | 1 | Idle and able to accept a block |

## Verification
The cipher is tried with a mixed-bit plaintext, with all zeros and with all ones. The all-zero block makes the first rotation amounts depend only on the keys. The all-ones block drives the multiply to its carry-heavy extreme. The mixed block separates a word-order or packing error from an arithmetic one. Every ciphertext is compared with an independent model of the equations, and every ciphertext is also decrypted back to its plaintext. Decryption compared with its own model tells a reversed round order apart from a wrong subtract/rotate order. Separate runs stall the key side in the middle of the rounds and hold the output side full, to separate correct step gating from accidental progress.

// File: rtl/quad_rot_pkg.sv
package quad_rot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ROUND,
    ST_POST,
    ST_DONE
  } ctrlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic preStep;
    logic roundStep;
    logic postStep;
    logic decrypt;
  } dpCtrl_t;

endpackage

// File: rtl/quad_rot_mix.sv
// Quadratic mixing term: rotl(x*(2x+1) mod 2^w, log2 w)
module quad_rot_mix #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] x,
  output logic [WORD_W-1:0] y
);
  localparam int LG = $clog2(WORD_W);

  logic [WORD_W-1:0] prod;

  always_comb begin
    prod = x * ((x << 1) + WORD_W'(1));
    y    = (prod << LG) | (prod >> (WORD_W - LG));
  end
endmodule

// File: rtl/quad_rot_datapath.sv
module quad_rot_datapath
  import quad_rot_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dpCtrl_t               ctrl,
  input  logic [4*WORD_W-1:0]   blockIn,
  input  logic [2*WORD_W-1:0]   keyWord,
  output logic [4*WORD_W-1:0]   blockOut
);
  localparam int LG = $clog2(WORD_W);

  logic [WORD_W-1:0] wA, wB, wC, wD;
  logic [WORD_W-1:0] nA, nB, nC, nD;
  logic [WORD_W-1:0] kEven, kOdd;
  logic [WORD_W-1:0] mixIn  [2];
  logic [WORD_W-1:0] mixOut [2];
  logic [WORD_W-1:0] tMix, uMix;

  function automatic logic [WORD_W-1:0] rotL(input logic [WORD_W-1:0] v,
                                             input logic [LG-1:0] s);
    rotL = (s == '0) ? v : ((v << s) | (v >> (WORD_W - int'(s))));
  endfunction

  function automatic logic [WORD_W-1:0] rotR(input logic [WORD_W-1:0] v,
                                             input logic [LG-1:0] s);
    rotR = (s == '0) ? v : ((v >> s) | (v << (WORD_W - int'(s))));
  endfunction

  assign kEven = keyWord[WORD_W-1:0];
  assign kOdd  = keyWord[2*WORD_W-1:WORD_W];

  // Decryption pre-moves words (D,A,B,C); its new B and D are old A and C.
  assign mixIn[0] = ctrl.decrypt ? wA : wB;  // source of t
  assign mixIn[1] = ctrl.decrypt ? wC : wD;  // source of u

  generate
    for (genvar g = 0; g < 2; g++) begin : g_mix
      quad_rot_mix #(.WORD_W(WORD_W)) i_mix (
        .x(mixIn[g]),
        .y(mixOut[g])
      );
    end
  endgenerate

  assign tMix = mixOut[0];
  assign uMix = mixOut[1];

  always_comb begin
    nA = wA; nB = wB; nC = wC; nD = wD;
    if (ctrl.preStep) begin
      if (ctrl.decrypt) begin
        nC = wC - kOdd;
        nA = wA - kEven;
      end else begin
        nB = wB + kEven;
        nD = wD + kOdd;
      end
    end else if (ctrl.roundStep) begin
      if (ctrl.decrypt) begin
        nA = rotR(wD - kEven, uMix[LG-1:0]) ^ tMix;
        nB = wA;
        nC = rotR(wB - kOdd, tMix[LG-1:0]) ^ uMix;
        nD = wC;
      end else begin
        nA = wB;
        nB = rotL(wC ^ uMix, tMix[LG-1:0]) + kOdd;
        nC = wD;
        nD = rotL(wA ^ tMix, uMix[LG-1:0]) + kEven;
      end
    end else if (ctrl.postStep) begin
      if (ctrl.decrypt) begin
        nD = wD - kOdd;
        nB = wB - kEven;
      end else begin
        nA = wA + kEven;
        nC = wC + kOdd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wA <= '0; wB <= '0; wC <= '0; wD <= '0;
    end else if (ctrl.load) begin
      {wA, wB, wC, wD} <= blockIn;
    end else begin
      wA <= nA; wB <= nB; wC <= nC; wD <= nD;
    end
  end

  assign blockOut = {wA, wB, wC, wD};
endmodule

// File: rtl/quad_rot_control.sv
module quad_rot_control
  import quad_rot_pkg::*;
#(
  parameter  int NUM_ROUNDS = 20,
  localparam int RN_W       = $clog2(NUM_ROUNDS + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            encSel,
  input  logic            inAvail,
  input  logic            keyAvail,
  input  logic            outFull,
  output logic            inRead,
  output logic            keyRead,
  output logic            outWrite,
  output logic            ready,
  output logic [RN_W-1:0] roundNum,
  output dpCtrl_t         ctrl
);
  localparam logic [RN_W-1:0] LAST_PAIR = RN_W'(NUM_ROUNDS + 1);
  localparam logic [RN_W-1:0] LAST_RND  = RN_W'(NUM_ROUNDS);

  ctrlState_t state;
  logic       dirDec;
  logic [RN_W-1:0] rnd;
  logic       busy;
  logic       lastRound;

  assign ready     = (state == ST_IDLE);
  assign inRead    = ready && inAvail;
  assign busy      = (state == ST_PRE) || (state == ST_ROUND) || (state == ST_POST);
  assign keyRead   = busy && keyAvail;
  assign outWrite  = (state == ST_DONE) && !outFull;
  assign lastRound = dirDec ? (rnd == RN_W'(1)) : (rnd == LAST_RND);
  assign roundNum  = rnd;

  always_comb begin
    ctrl           = '0;
    ctrl.load      = inRead;
    ctrl.preStep   = (state == ST_PRE)   && keyAvail;
    ctrl.roundStep = (state == ST_ROUND) && keyAvail;
    ctrl.postStep  = (state == ST_POST)  && keyAvail;
    ctrl.decrypt   = dirDec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      dirDec <= 1'b0;
      rnd    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (inRead) begin
          dirDec <= !encSel;
          rnd    <= encSel ? '0 : LAST_PAIR;
          state  <= ST_PRE;
        end
        ST_PRE: if (keyAvail) begin
          rnd   <= dirDec ? rnd - RN_W'(1) : rnd + RN_W'(1);
          state <= ST_ROUND;
        end
        ST_ROUND: if (keyAvail) begin
          rnd <= dirDec ? rnd - RN_W'(1) : rnd + RN_W'(1);
          if (lastRound) state <= ST_POST;
        end
        ST_POST: if (keyAvail) state <= ST_DONE;
        ST_DONE: if (outWrite) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/quad_rot_cipher.sv
module quad_rot_cipher
  import quad_rot_pkg::*;
#(
  parameter  int WORD_W     = 32,
  parameter  int NUM_ROUNDS = 20,
  localparam int RN_W       = $clog2(NUM_ROUNDS + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                encSel,
  input  logic [4*WORD_W-1:0] dataIn,
  input  logic                inAvail,
  output logic                inRead,
  output logic [4*WORD_W-1:0] dataOut,
  input  logic                outFull,
  output logic                outWrite,
  output logic [RN_W-1:0]     roundNum,
  input  logic [2*WORD_W-1:0] keyWord,
  input  logic                keyAvail,
  output logic                keyRead,
  output logic                ready
);
  dpCtrl_t ctrl;

  quad_rot_control #(.NUM_ROUNDS(NUM_ROUNDS)) i_control (
    .clk      (clk),
    .rst_n    (rst_n),
    .encSel   (encSel),
    .inAvail  (inAvail),
    .keyAvail (keyAvail),
    .outFull  (outFull),
    .inRead   (inRead),
    .keyRead  (keyRead),
    .outWrite (outWrite),
    .ready    (ready),
    .roundNum (roundNum),
    .ctrl     (ctrl)
  );

  quad_rot_datapath #(.WORD_W(WORD_W)) i_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .blockIn  (dataIn),
    .keyWord  (keyWord),
    .blockOut (dataOut)
  );
endmodule

// File: rtl/quad_rot_checker.sv
module quad_rot_checker #(
  parameter  int WORD_W     = 32,
  parameter  int NUM_ROUNDS = 20,
  localparam int RN_W       = $clog2(NUM_ROUNDS + 2)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                inAvail,
  input logic                inRead,
  input logic [4*WORD_W-1:0] dataOut,
  input logic                outFull,
  input logic                outWrite,
  input logic [RN_W-1:0]     roundNum,
  input logic                keyAvail,
  input logic                keyRead,
  input logic                ready
);
  AST_KEY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    keyRead |-> keyAvail);  // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inRead, keyRead, outWrite}));  // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(keyRead) && !$past(inRead)) |-> $stable(dataOut));  // R4
  AST_BUSY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (inRead && inAvail) |=> !ready);  // R6
  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    outWrite |-> !outFull);  // R7
  AST_IDLE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    outWrite |=> ready);  // R7
  AST_PAIR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    roundNum <= RN_W'(NUM_ROUNDS + 1));  // R9
endmodule

bind quad_rot_cipher quad_rot_checker #(.WORD_W(WORD_W), .NUM_ROUNDS(NUM_ROUNDS)) i_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .inAvail  (inAvail),
  .inRead   (inRead),
  .dataOut  (dataOut),
  .outFull  (outFull),
  .outWrite (outWrite),
  .roundNum (roundNum),
  .keyAvail (keyAvail),
  .keyRead  (keyRead),
  .ready    (ready)
);

// File: tb/test_quad_rot_cipher.sv
`timescale 1ns/1ps
module test_quad_rot_cipher;
  localparam int W = 32;
  localparam int R = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         encSel = 1'b1;
  logic [127:0] dataIn = '0;
  logic         inAvail = 1'b0;
  logic         inRead;
  logic [127:0] dataOut;
  logic         outFull = 1'b0;
  logic         outWrite;
  logic [4:0]   roundNum;
  logic [63:0]  keyWord;
  logic         keyAvail = 1'b1;
  logic         keyRead;
  logic         ready;

  int checks = 0;
  int errors = 0;

  logic [31:0] keyTab [0:2*R+3];

  always #5 clk = ~clk;

  quad_rot_cipher #(.WORD_W(W), .NUM_ROUNDS(R)) i_quad_rot_cipher (
    .clk(clk), .rst_n(rst_n), .encSel(encSel), .dataIn(dataIn),
    .inAvail(inAvail), .inRead(inRead), .dataOut(dataOut),
    .outFull(outFull), .outWrite(outWrite), .roundNum(roundNum),
    .keyWord(keyWord), .keyAvail(keyAvail), .keyRead(keyRead), .ready(ready)
  );

  // External key memory model: pair p -> {S[2p+1], S[2p]} (R2)
  always_comb begin
    if (int'(roundNum) <= R + 1)
      keyWord = {keyTab[2*int'(roundNum)+1], keyTab[2*int'(roundNum)]};
    else
      keyWord = '0;
  end

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input logic [31:0] s);
    int n = int'(s[4:0]);
    return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
  endfunction

  function automatic logic [31:0] rr(input logic [31:0] x, input logic [31:0] s);
    int n = int'(s[4:0]);
    return (n == 0) ? x : ((x >> n) | (x << (32 - n)));
  endfunction

  function automatic logic [31:0] mixf(input logic [31:0] x);
    logic [31:0] p;
    p = x * ((x << 1) + 32'd1);
    return rl(p, 32'd5);
  endfunction

  function automatic logic [127:0] encModel(input logic [127:0] blk);
    logic [31:0] a, b, c, d, t, u, tmp;
    {a, b, c, d} = blk;
    b = b + keyTab[0];
    d = d + keyTab[1];
    for (int i = 1; i <= R; i++) begin
      t = mixf(b);
      u = mixf(d);
      a = rl(a ^ t, u) + keyTab[2*i];
      c = rl(c ^ u, t) + keyTab[2*i+1];
      tmp = a; a = b; b = c; c = d; d = tmp;
    end
    a = a + keyTab[2*R+2];
    c = c + keyTab[2*R+3];
    return {a, b, c, d};
  endfunction

  function automatic logic [127:0] decModel(input logic [127:0] blk);
    logic [31:0] a, b, c, d, t, u, tmp;
    {a, b, c, d} = blk;
    c = c - keyTab[2*R+3];
    a = a - keyTab[2*R+2];
    for (int i = R; i >= 1; i--) begin
      tmp = d; d = c; c = b; b = a; a = tmp;
      u = mixf(d);
      t = mixf(b);
      c = rr(c - keyTab[2*i+1], t) ^ u;
      a = rr(a - keyTab[2*i], u) ^ t;
    end
    d = d - keyTab[1];
    b = b - keyTab[0];
    return {a, b, c, d};
  endfunction

  // One job: accept, optional key stall, optional output hold
  task automatic runBlock(input bit enc, input logic [127:0] blk,
                          input int stallAt, input int stallLen,
                          input int extraFull, input bit probe,
                          output logic [127:0] res, output int lat);
    int fullUntil;
    int doneAt;
    int k;
    logic [127:0] held;
    fullUntil = (extraFull > 0) ? (R + 3 + stallLen + extraFull) : 0;
    doneAt = R + 3 + stallLen;
    res = '0;
    lat = -1;
    @(posedge clk); #1;
    encSel = enc; dataIn = blk; inAvail = 1'b1; keyAvail = 1'b1;
    outFull = (fullUntil > 0);
    k = 0;
    forever begin
      @(negedge clk);
      if (inRead) break;
      k++;
      if (k > 100) break;
    end
    chk("R6", "ready during accept", {127'd0, ready}, 128'd1);
    k = 0;
    held = '0;
    forever begin
      @(posedge clk); #1;
      k++;
      keyAvail = !(k > stallAt && k <= stallAt + stallLen);
      outFull  = (k < fullUntil);
      inAvail  = probe && (k >= doneAt) && (k < fullUntil);
      @(negedge clk);
      if (k == 1) begin
        chk("R6", "ready while busy", {127'd0, ready}, 128'd0);
        chk("R9", "first pair index", {123'd0, roundNum}, enc ? 128'd0 : 128'(R + 1));
      end
      if (k == 2 && stallAt >= 2)
        chk("R9", "second pair index", {123'd0, roundNum}, enc ? 128'd1 : 128'(R));
      if (k == doneAt) held = dataOut;
      if (k > doneAt && k < fullUntil) begin
        chk("R7", "no write while full", {127'd0, outWrite}, 128'd0);
        chk("R7", "output held", dataOut, held);
        if (probe) chk("R7", "no accept while holding", {127'd0, inRead}, 128'd0);
      end
      if (outWrite) begin
        res = dataOut;
        lat = k;
        break;
      end
      if (k > 500) break;
    end
    inAvail = 1'b0;
    @(posedge clk); #1;
    outFull = 1'b0;
    keyAvail = 1'b1;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R8", "ready", {127'd0, ready}, 128'd1);
    chk("R8", "inRead", {127'd0, inRead}, 128'd0);
    chk("R8", "keyRead", {127'd0, keyRead}, 128'd0);
    chk("R8", "outWrite", {127'd0, outWrite}, 128'd0);
    chk("R8", "dataOut", dataOut, 128'd0);
  endtask

  task automatic testEncVectors();
    logic [127:0] vecs [3];
    logic [127:0] res;
    int lat;
    vecs[0] = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    vecs[1] = '0;
    vecs[2] = '1;
    foreach (vecs[i]) begin
      runBlock(1'b1, vecs[i], 1000, 0, 0, 1'b0, res, lat);
      chk("R1", $sformatf("encrypt vector %0d", i), res, encModel(vecs[i]));
      chk("R5", "latency no stall", 128'(lat), 128'(R + 3));
    end
  endtask

  task automatic testRoundTrip();
    logic [127:0] vecs [2];
    logic [127:0] ct, pt;
    int lat;
    vecs[0] = 128'hDEAD_BEEF_0000_0001_8000_0000_1357_9BDF;
    vecs[1] = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    foreach (vecs[i]) begin
      runBlock(1'b1, vecs[i], 1000, 0, 0, 1'b0, ct, lat);
      chk("R1", "encrypt before round trip", ct, encModel(vecs[i]));
      runBlock(1'b0, ct, 1000, 0, 0, 1'b0, pt, lat);
      chk("R3", "decrypt returns plaintext", pt, vecs[i]);
      chk("R3", "decrypt against model", pt, decModel(ct));
    end
  endtask

  task automatic testKeyStall();
    logic [127:0] blk = 128'hA5A5_5A5A_C3C3_3C3C_0F0F_F0F0_1234_ABCD;
    logic [127:0] res;
    int lat;
    runBlock(1'b1, blk, 3, 4, 0, 1'b0, res, lat);
    chk("R4", "result with key stall", res, encModel(blk));
    chk("R5", "latency with 4 stall cycles", 128'(lat), 128'(R + 7));
    runBlock(1'b0, res, 10, 2, 0, 1'b0, res, lat);
    chk("R3", "decrypt with key stall", res, blk);
    chk("R5", "decrypt latency with stall", 128'(lat), 128'(R + 5));
  endtask

  task automatic testBackpressure();
    logic [127:0] blk = 128'h0BAD_F00D_CAFE_BABE_0000_FFFF_FFFF_0000;
    logic [127:0] res;
    int lat;
    runBlock(1'b1, blk, 1000, 0, 5, 1'b1, res, lat);
    chk("R7", "result after hold", res, encModel(blk));
    chk("R7", "write on release", 128'(lat), 128'(R + 8));
    @(negedge clk);
    chk("R7", "ready after transfer", {127'd0, ready}, 128'd1);
  endtask

  initial begin
    for (int k = 0; k < 2*R+4; k++)
      keyTab[k] = 32'hB7E1_5163 + 32'(k) * 32'h9E37_79B9 ^ (32'(k) << 24);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    testReset();
    testEncVectors();
    testRoundTrip();
    testKeyStall();
    testBackpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule